// File: doc/BRIEF.md
# One-Shot Message Interrupt Request Controller

This block decides when the device sends a message-signaled interrupt. Interrupt events and three kinds of bus error pulse come in from the device. The block drives one request line, `msg_req`, toward a bus interface. That interface builds and sends the message and then returns a one-cycle `msg_done`. Software reaches the block through a small register port that holds a control word and a status word. A mailbox write port carries the tag byte that software writes back.

In one-shot mode, each message masks the block until software writes the mailbox with the tag last delivered to the host. One-shot mode needs both the tagged-interrupt mode input and a control bit that leaves it enabled. When the enable bit is cleared, a request that is already under way still finishes, and the controller halts only after that. A soft reset bit returns the machine to idle without touching the configuration.

Top module: `msi_oneshot_ctrl`

## Requirements
- R1: After `rst_n` is released, the control word reads 0x00000002, the status word reads 0, and `msg_req` is 0.
- R2: An `irq_evt` pulse raises `msg_req`. The request stays high until `msg_done` is sampled high, and is low in the cycle after that.
- R3: An event that arrives while a request is in flight, while the controller is masked, or while it is halted is held pending. It is issued later and is never dropped.
- R4: One-shot mode is active when `tag_mode`=1 and control bit 5 is 0. In that mode, each issued message sets a mask that blocks further requests.
- R5: A mailbox write whose tag (`mbox_tag`, bits 31:24 of the mailbox word) equals `last_tag` clears the mask. A write with any other tag leaves the mask set.
- R6: When `tag_mode`=0 or control bit 5 is 1, no mask is applied, and every event produces its own message.
- R7: Error pulses latch into status bits 2 (`err_tabort`), 3 (`err_mabort`) and 4 (`err_parity`). Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged.
- R8: If control bit 2, 3 or 4 (the attention enable for the matching error) is 1, the error pulse also raises a message request. If the bit is 0, the error only latches its status bit.
- R9: Status bit 0 reads the current value of `msg_req`. Writing 1 to it forces a request, and writing 0 has no effect.
- R10: Control bit 1 is the enable. When it is cleared, an in-flight request still completes, and the bit keeps reading 1 until the machine has halted. While halted, the block issues no request. Setting the bit again resumes operation and issues any pending event.
- R11: Writing 1 to control bit 0 drops any request and clears both the mask and the pending event. Control bit 0 reads 1 in the cycle after the write and 0 after that.
- R12: Control bits 31:6 and status bits 31:5 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_evt | input | 1 | Interrupt event pulse from the device |
| err_tabort | input | 1 | Target-abort error pulse |
| err_mabort | input | 1 | Master-abort error pulse |
| err_parity | input | 1 | Parity error pulse |
| tag_mode | input | 1 | Tagged interrupt mode; one-shot mode requires it |
| last_tag | input | 8 | Tag most recently reported to the host |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 6 | Register write data (bits 5:0; upper bits have no function) |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mbox_wr | input | 1 | Mailbox write strobe |
| mbox_tag | input | 8 | Tag byte of the mailbox word (bits 31:24) |
| msg_req | output | 1 | Message request to the bus interface |
| msg_done | input | 1 | One-cycle completion pulse from the bus interface |

## Verification
A wrong mask or pending bit shows up at `msg_req`. A request is either missing or extra within two clock edges of the event or mailbox write that should have decided it. A wrong machine state appears as soon as the enable and request bits are read back, and also when a request fails to fall in the cycle after `msg_done`. The tag compare is swept over all 256 mailbox values for several host tags, and the error latches are swept over every error and enable combination.

// File: rtl/msi_pkg.sv
// Package: shared state encoding and register bit positions for the
// message interrupt controller. Assumes 32-bit register reads.
package msi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HALT = 2'd2
    } msi_state_e;

    localparam int RD_W          = 32;
    localparam int WR_W          = 6;
    localparam int NUM_ERR       = 3;
    // control word bit positions
    localparam int CTL_SRST      = 0;
    localparam int CTL_EN        = 1;
    localparam int CTL_ATTN_LSB  = 2;
    localparam int CTL_OS_DIS    = 5;
    // status word bit positions
    localparam int STS_REQ       = 0;
    localparam int STS_ERR_LSB   = 2;

endpackage

// File: rtl/msi_regs.sv
// Register file: control and status words, error latches, readback.
// Assumes writes take effect at the clock edge where reg_wr is high;
// the soft-reset and force-request strobes are combinational from the write.
module msi_regs
    import msi_pkg::*;
#(
    parameter int NERR = NUM_ERR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [WR_W-1:0]  reg_wdata,
    input  logic [NERR-1:0]  err_evt,
    input  logic             msg_req,
    input  logic             halted,
    output logic [RD_W-1:0]  reg_rdata,
    output logic             en_cfg,
    output logic             os_dis,
    output logic             soft_rst,
    output logic             force_req,
    output logic             attn_raise,
    output logic [NERR-1:0]  err_q
);
    localparam int ATTN_MSB = CTL_ATTN_LSB + NERR - 1;
    localparam int ERR_MSB  = STS_ERR_LSB + NERR - 1;

    logic            ctl_wr;
    logic            sts_wr;
    logic            srst_flag;
    logic [NERR-1:0] attn_en;
    logic [NERR-1:0] err_clr;

    assign ctl_wr    = reg_wr && !reg_sel;
    assign sts_wr    = reg_wr && reg_sel;
    assign soft_rst  = ctl_wr && reg_wdata[CTL_SRST];
    assign force_req = sts_wr && reg_wdata[STS_REQ];
    assign err_clr   = sts_wr ? reg_wdata[ERR_MSB:STS_ERR_LSB] : '0;
    assign attn_raise = |(err_evt & attn_en);

    // Purpose: hold the control configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_cfg  <= 1'b1;
            os_dis  <= 1'b0;
            attn_en <= '0;
        end else if (ctl_wr) begin
            en_cfg  <= reg_wdata[CTL_EN];
            os_dis  <= reg_wdata[CTL_OS_DIS];
            attn_en <= reg_wdata[ATTN_MSB:CTL_ATTN_LSB];
        end
    end

    // Purpose: self-clearing readback of the soft reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_flag <= 1'b0;
        else        srst_flag <= soft_rst;
    end

    // Purpose: error status latches, write-one-to-clear, new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_evt;
    end

    // Purpose: combinational read mux for the selected word.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[STS_REQ]               = msg_req;
            reg_rdata[ERR_MSB:STS_ERR_LSB]   = err_q;
        end else begin
            reg_rdata[CTL_SRST]              = srst_flag;
            reg_rdata[CTL_EN]                = en_cfg || !halted;
            reg_rdata[ATTN_MSB:CTL_ATTN_LSB] = attn_en;
            reg_rdata[CTL_OS_DIS]            = os_dis;
        end
    end

endmodule

// File: rtl/msi_gate.sv
// Pending event and one-shot mask unit with the tag comparator.
// Assumes 'issue' is high in the cycle the request machine enters the
// request state; a new event in that same cycle stays pending.
module msi_gate
    import msi_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_evt,
    input  logic             attn_raise,
    input  logic             issue,
    input  logic             soft_rst,
    input  logic             tag_mode,
    input  logic             os_dis,
    input  logic             mbox_wr,
    input  logic [TAG_W-1:0] mbox_tag,
    input  logic [TAG_W-1:0] last_tag,
    output logic             pending,
    output logic             mask_eff
);
    logic oneshot_act;
    logic tag_hit;
    logic mask_q;

    assign oneshot_act = tag_mode && !os_dis;
    assign tag_hit     = mbox_wr && (mbox_tag == last_tag);
    assign mask_eff    = mask_q && oneshot_act;

    // Purpose: remember an unserved event until a message is issued.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)          pending <= 1'b0;
        else if (irq_evt || attn_raise)  pending <= 1'b1;
        else if (issue)                  pending <= 1'b0;
    end

    // Purpose: auto-mask on issue in one-shot mode, unmask on tag match.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)          mask_q <= 1'b0;
        else if (issue && oneshot_act)   mask_q <= 1'b1;
        else if (tag_hit)                mask_q <= 1'b0;
    end

endmodule

// File: rtl/msi_fsm.sv
// Request state machine: idle, requesting, halted.
// Assumes msg_done is a single-cycle pulse only meaningful while requesting.
module msi_fsm
    import msi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cfg,
    input  logic pending,
    input  logic mask_eff,
    input  logic force_req,
    input  logic soft_rst,
    input  logic msg_done,
    output logic issue,
    output logic msg_req,
    output logic halted
);
    msi_state_e state_q;
    msi_state_e state_d;

    // Purpose: next-state selection with soft reset and forced request first.
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_IDLE;
        end else if (force_req && state_q != ST_REQ) begin
            state_d = ST_REQ;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!en_cfg)                   state_d = ST_HALT;
                    else if (pending && !mask_eff) state_d = ST_REQ;
                end
                ST_REQ: begin
                    if (msg_done) state_d = en_cfg ? ST_IDLE : ST_HALT;
                end
                ST_HALT: begin
                    if (en_cfg) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign issue   = (state_d == ST_REQ) && (state_q != ST_REQ);
    assign msg_req = (state_q == ST_REQ);
    assign halted  = (state_q == ST_HALT);

endmodule

// File: rtl/msi_oneshot_ctrl.sv
// Top: one-shot message interrupt request controller.
// Assumes all inputs are synchronous to clk and event inputs are pulses.
module msi_oneshot_ctrl
    import msi_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int NERR  = NUM_ERR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_evt,
    input  logic              err_tabort,
    input  logic              err_mabort,
    input  logic              err_parity,
    input  logic              tag_mode,
    input  logic [TAG_W-1:0]  last_tag,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WR_W-1:0]   reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    input  logic              mbox_wr,
    input  logic [TAG_W-1:0]  mbox_tag,
    output logic              msg_req,
    input  logic              msg_done
);
    logic [NERR-1:0] err_evt;
    logic [NERR-1:0] err_q;
    logic en_cfg, os_dis, soft_rst, force_req, attn_raise;
    logic pending, mask_eff, issue, halted;

    assign err_evt = {err_parity, err_mabort, err_tabort};

    msi_regs #(.NERR(NERR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .err_evt    (err_evt),
        .msg_req    (msg_req),
        .halted     (halted),
        .reg_rdata  (reg_rdata),
        .en_cfg     (en_cfg),
        .os_dis     (os_dis),
        .soft_rst   (soft_rst),
        .force_req  (force_req),
        .attn_raise (attn_raise),
        .err_q      (err_q)
    );

    msi_gate #(.TAG_W(TAG_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_evt    (irq_evt),
        .attn_raise (attn_raise),
        .issue      (issue),
        .soft_rst   (soft_rst),
        .tag_mode   (tag_mode),
        .os_dis     (os_dis),
        .mbox_wr    (mbox_wr),
        .mbox_tag   (mbox_tag),
        .last_tag   (last_tag),
        .pending    (pending),
        .mask_eff   (mask_eff)
    );

    msi_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_cfg     (en_cfg),
        .pending    (pending),
        .mask_eff   (mask_eff),
        .force_req  (force_req),
        .soft_rst   (soft_rst),
        .msg_done   (msg_done),
        .issue      (issue),
        .msg_req    (msg_req),
        .halted     (halted)
    );

endmodule

// File: rtl/msi_oneshot_chk.sv
// Checker: temporal properties of the controller, bound to the top module.
module msi_oneshot_chk
    import msi_pkg::*;
#(
    parameter int NERR = NUM_ERR
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [WR_W-1:0]  reg_wdata,
    input logic [RD_W-1:0]  reg_rdata,
    input logic             msg_req,
    input logic             msg_done,
    input logic             halted,
    input logic [NERR-1:0]  err_evt,
    input logic [NERR-1:0]  err_q
);
    logic srst_wr;
    assign srst_wr = reg_wr && !reg_sel && reg_wdata[CTL_SRST];

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_done && !srst_wr) |=> msg_req);

    assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && msg_done) |=> !msg_req);

    assert_sts_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[STS_REQ] == msg_req));

    assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[RD_W-1:5] == '0 && !reg_rdata[1]));

    assert_ctl_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[RD_W-1:WR_W] == '0));

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !msg_req);

    assert_srst_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> !msg_req);

    for (genvar i = 0; i < NERR; i++) begin : g_err
        assert_err_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
            err_evt[i] |=> err_q[i]);
    end

endmodule

bind msi_oneshot_ctrl msi_oneshot_chk #(.NERR(NERR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .msg_req   (msg_req),
    .msg_done  (msg_done),
    .halted    (halted),
    .err_evt   (err_evt),
    .err_q     (err_q)
);

// File: tb/sim_msi_oneshot_ctrl.sv
module sim_msi_oneshot_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_evt = 1'b0;
    logic        err_tabort = 1'b0, err_mabort = 1'b0, err_parity = 1'b0;
    logic        tag_mode = 1'b0;
    logic [7:0]  last_tag = 8'h00;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [5:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mbox_wr = 1'b0;
    logic [7:0]  mbox_tag = 8'h00;
    logic        msg_req;
    logic        msg_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_oneshot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt),
        .err_tabort(err_tabort), .err_mabort(err_mabort), .err_parity(err_parity),
        .tag_mode(tag_mode), .last_tag(last_tag),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mbox_wr(mbox_wr), .mbox_tag(mbox_tag), .msg_req(msg_req), .msg_done(msg_done)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [5:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_irq();
        irq_evt = 1'b1; cyc(); irq_evt = 1'b0;
    endtask

    task automatic pulse_done();
        msg_done = 1'b1; cyc(); msg_done = 1'b0;
    endtask

    task automatic write_mbox(input logic [7:0] t);
        mbox_wr = 1'b1; mbox_tag = t; cyc(); mbox_wr = 1'b0;
    endtask

    task automatic wait_req(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (!seen) begin
                cyc();
                if (msg_req) seen = 1'b1;
            end
        end
    endtask

    task automatic quiet(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (msg_req) seen = 1'b1;
        end
    endtask

    initial begin
        logic [31:0] rd;
        bit s;
        logic [7:0] host_tags [3];
        host_tags[0] = 8'h00; host_tags[1] = 8'h5A; host_tags[2] = 8'hFF;

        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 / R12: reset values
        rd_reg(1'b0, rd); chk(rd == 32'h2, "R1 ctrl reset", rd, 32'h2);
        rd_reg(1'b1, rd); chk(rd == 32'h0, "R1 status reset", rd, 32'h0);
        chk(msg_req == 1'b0, "R1 req reset", {31'b0, msg_req}, 32'h0);

        // R2: event -> request, held until done
        pulse_irq();
        wait_req(3, s); chk(s, "R2 irq raises request", {31'b0, s}, 1);
        repeat (5) cyc();
        chk(msg_req, "R2 request held", {31'b0, msg_req}, 1);
        pulse_done();
        chk(!msg_req, "R2 request drops after done", {31'b0, msg_req}, 0);

        // R3 / R6: event during busy kept pending; tag_mode=0 so no mask
        pulse_irq();
        wait_req(3, s); chk(s, "R3 first request", {31'b0, s}, 1);
        pulse_irq();
        pulse_done();
        chk(!msg_req, "R3 drop between messages", {31'b0, msg_req}, 0);
        wait_req(3, s); chk(s, "R3 R6 pending event issued", {31'b0, s}, 1);
        pulse_done();
        quiet(4, s); chk(!s, "R3 no spurious request", {31'b0, s}, 0);

        // R4 / R5: one-shot mask with tag sweep
        tag_mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            last_tag = host_tags[k];
            pulse_irq();
            wait_req(3, s); chk(s, "R4 one-shot first message", {31'b0, s}, 1);
            pulse_done();
            pulse_irq();
            quiet(5, s); chk(!s, "R4 masked after message", {31'b0, s}, 0);
            for (int t = 0; t < 256; t++) begin
                if (t[7:0] != host_tags[k]) begin
                    write_mbox(t[7:0]);
                    cyc();
                    chk(!msg_req, "R5 wrong tag keeps mask", {24'b0, t[7:0]}, {24'b0, host_tags[k]});
                end
            end
            write_mbox(host_tags[k]);
            wait_req(3, s); chk(s, "R5 R3 matching tag releases pending", {31'b0, s}, 1);
            pulse_done();
            write_mbox(host_tags[k]);
            cyc();
        end

        // R6: one-shot disable bit
        wr_reg(1'b0, 6'h22);
        pulse_irq();
        wait_req(3, s); chk(s, "R6 first message", {31'b0, s}, 1);
        pulse_done();
        pulse_irq();
        wait_req(3, s); chk(s, "R6 no mask with disable bit", {31'b0, s}, 1);
        pulse_done();
        wr_reg(1'b0, 6'h02);
        tag_mode = 1'b0;

        // R7 / R8: error latches and attention enables
        for (int e = 0; e < 3; e++) begin
            for (int en = 0; en < 2; en++) begin
                wr_reg(1'b0, 6'h02 | (en[5:0] << (2 + e)));
                err_tabort = (e == 0); err_mabort = (e == 1); err_parity = (e == 2);
                cyc();
                err_tabort = 1'b0; err_mabort = 1'b0; err_parity = 1'b0;
                rd_reg(1'b1, rd);
                chk(rd[4:2] == (3'b1 << e), "R7 error latched", {29'b0, rd[4:2]}, {29'b0, 3'b1 << e});
                wait_req(4, s);
                chk(s == en[0], "R8 attention enable", {31'b0, s}, en);
                if (s) pulse_done();
                wr_reg(1'b1, 6'h00);
                rd_reg(1'b1, rd);
                chk(rd[2 + e], "R7 write zero keeps bit", rd, 32'h1 << (2 + e));
                wr_reg(1'b1, 6'h01 << (2 + e));
                rd_reg(1'b1, rd);
                chk(rd == 32'h0, "R7 R12 write one clears", rd, 32'h0);
            end
        end
        wr_reg(1'b0, 6'h02);

        // R9: forced request via status bit 0
        wr_reg(1'b1, 6'h01);
        chk(msg_req, "R9 forced request", {31'b0, msg_req}, 1);
        rd_reg(1'b1, rd); chk(rd == 32'h1, "R9 status shows request", rd, 32'h1);
        pulse_done();
        wr_reg(1'b1, 6'h00);
        quiet(4, s); chk(!s, "R9 write zero no effect", {31'b0, s}, 0);

        // R10: clean halt
        pulse_irq();
        wait_req(3, s); chk(s, "R10 request before disable", {31'b0, s}, 1);
        wr_reg(1'b0, 6'h00);
        rd_reg(1'b0, rd); chk(rd[1], "R10 enable reads 1 while busy", rd, 32'h2);
        chk(msg_req, "R10 request finishes", {31'b0, msg_req}, 1);
        pulse_done();
        rd_reg(1'b0, rd); chk(rd == 32'h0, "R10 enable reads 0 when halted", rd, 32'h0);
        pulse_irq();
        quiet(5, s); chk(!s, "R10 halted issues nothing", {31'b0, s}, 0);
        wr_reg(1'b0, 6'h02);
        wait_req(4, s); chk(s, "R10 R3 resume issues pending", {31'b0, s}, 1);
        pulse_done();

        // R11: soft reset
        tag_mode = 1'b1;
        last_tag = 8'h33;
        pulse_irq();
        wait_req(3, s); chk(s, "R11 request before soft reset", {31'b0, s}, 1);
        wr_reg(1'b0, 6'h03);
        chk(!msg_req, "R11 soft reset drops request", {31'b0, msg_req}, 0);
        rd_reg(1'b0, rd); chk(rd == 32'h3, "R11 reset bit reads 1", rd, 32'h3);
        cyc();
        rd_reg(1'b0, rd); chk(rd == 32'h2, "R11 reset bit self-clears", rd, 32'h2);
        pulse_irq();
        wait_req(3, s); chk(s, "R11 mask cleared by soft reset", {31'b0, s}, 1);
        pulse_done();
        pulse_irq();
        quiet(3, s); chk(!s, "R4 masked before soft reset", {31'b0, s}, 0);
        wr_reg(1'b0, 6'h03);
        quiet(6, s); chk(!s, "R11 pending cleared by soft reset", {31'b0, s}, 0);
        pulse_irq();
        wait_req(3, s); chk(s, "R11 operation after soft reset", {31'b0, s}, 1);
        pulse_done();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule